// File: doc/BRIEF.md
# Variable Block OR Evaluator

This block stores a square binary image and answers one question per query: does any set pixel lie inside a chosen aligned square block? The image is written one full row at a time through a row-wide write port. A query gives a tree level and the coordinate of any pixel inside the wanted block. From these, a row decoder and a column decoder each enable a contiguous, aligned run of lines.

The answer comes from a reduction in two stages. In the first stage, each column is ORed over the enabled rows. In the second stage, the results of the enabled columns are ORed into one bit. A search that narrows a bright spot level by level can then descend only into the quadrants that report a hit, and skip the rest of the image.

The answer is registered. It appears together with an acknowledge exactly one cycle after the query is accepted.

Top module: `vbo_block_or`

## Requirements
- R1: After reset, q_ack and q_hit are 0 and every stored pixel is 0, so any query answers 0.
- R2: When wr_en is high at a clock edge, the row at wr_row takes the value wr_data, with pixel column c equal to wr_data[c]. Queries accepted at any later edge see the new row.
- R3: A query at level L (0..SIDE_LOG2) covers a block of side SIDE>>L. Row r is in the block when r>>(SIDE_LOG2-L) equals q_row>>(SIDE_LOG2-L), and column c is in the block under the same rule applied to q_col.
- R4: The answer q_hit is the OR of every stored pixel inside the selected block.
- R5: Level 0 covers the whole image, and level SIDE_LOG2 covers exactly the single pixel (q_row, q_col).
- R6: A level value above SIDE_LOG2 is treated as SIDE_LOG2.
- R7: A query is accepted at a clock edge where q_req is 1 and wr_en is 0. q_ack is 1 in exactly the following cycle, and q_hit carries the answer in that cycle.
- R8: When q_req and wr_en are both high at the same edge, the query is not accepted and q_ack stays 0 in the next cycle. The write still takes effect.
- R9: q_hit is 0 in every cycle in which q_ack is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Row write strobe |
| wr_row | input | SIDE_LOG2 | Row index to write |
| wr_data | input | SIDE | Pixel values for the row; bit c is column c |
| q_req | input | 1 | Query request |
| q_level | input | LVL_W | Tree level of the block |
| q_row | input | SIDE_LOG2 | Row of any pixel inside the block |
| q_col | input | SIDE_LOG2 | Column of any pixel inside the block |
| q_ack | output | 1 | Answer valid; high one cycle after an accepted query |
| q_hit | output | 1 | 1 when the block holds a set pixel |

## Verification
The bench builds the block with SIDE_LOG2 = 4, which gives a 16 by 16 image and levels 0 to 4. At that size, every level, every quadrant split and the single-pixel case can be reached with a short table of queries against a sparse image. The three-bit level field still allows the out-of-range values 5 to 7, so the clamping rule can be checked. The same size keeps the rows short enough to clear whole rows and to write a row in the same cycle as a rejected query.

// File: rtl/vbo_pkg.sv
package vbo_pkg;

  // Level actually used: anything past the finest level is clamped.
  function automatic int eff_level(int lvl, int max_lvl);
    return (lvl > max_lvl) ? max_lvl : lvl;
  endfunction

  // Line idx belongs to the block holding ref_idx when both agree above
  // the low span_log2 bits.
  function automatic logic same_block(int idx, int ref_idx, int span_log2);
    return (idx >> span_log2) == (ref_idx >> span_log2);
  endfunction

endpackage

// File: rtl/vbo_range_dec.sv
module vbo_range_dec #(
  parameter int SIDE_LOG2 = 8,
  localparam int SIDE = 1 << SIDE_LOG2,
  localparam int SPAN_W = $clog2(SIDE_LOG2 + 1)
) (
  input  logic [SIDE_LOG2-1:0] addr,
  input  logic [SPAN_W-1:0]    span_log2,
  output logic [SIDE-1:0]      sel
);
  for (genvar i = 0; i < SIDE; i++) begin : g_line
    assign sel[i] = vbo_pkg::same_block(i, int'(addr), int'(span_log2));
  end
endmodule

// File: rtl/vbo_img_store.sv
module vbo_img_store #(
  parameter int SIDE_LOG2 = 8,
  localparam int SIDE = 1 << SIDE_LOG2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SIDE_LOG2-1:0] wr_row,
  input  logic [SIDE-1:0]      wr_data,
  output logic [SIDE-1:0]      rows [SIDE]
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < SIDE; r++) rows[r] <= '0;
    end else if (wr_en) begin
      rows[wr_row] <= wr_data;
    end
  end
endmodule

// File: rtl/vbo_or_reduce.sv
module vbo_or_reduce #(
  parameter int SIDE_LOG2 = 8,
  localparam int SIDE = 1 << SIDE_LOG2
) (
  input  logic [SIDE-1:0] rows [SIDE],
  input  logic [SIDE-1:0] row_sel,
  input  logic [SIDE-1:0] col_sel,
  output logic [SIDE-1:0] col_any,
  output logic            hit
);
  // Stage one: per-column OR over the enabled rows.
  always_comb begin
    col_any = '0;
    for (int r = 0; r < SIDE; r++) begin
      if (row_sel[r]) col_any = col_any | rows[r];
    end
  end
  // Stage two: OR over the enabled columns.
  assign hit = |(col_any & col_sel);
endmodule

// File: rtl/vbo_block_or.sv
module vbo_block_or #(
  parameter int SIDE_LOG2 = 8,
  localparam int SIDE = 1 << SIDE_LOG2,
  localparam int LVL_W = $clog2(SIDE_LOG2 + 1),
  localparam int SPAN_W = LVL_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SIDE_LOG2-1:0] wr_row,
  input  logic [SIDE-1:0]      wr_data,
  input  logic                 q_req,
  input  logic [LVL_W-1:0]     q_level,
  input  logic [SIDE_LOG2-1:0] q_row,
  input  logic [SIDE_LOG2-1:0] q_col,
  output logic                 q_ack,
  output logic                 q_hit
);
  logic [SIDE-1:0]   rows [SIDE];
  logic [SIDE-1:0]   row_sel;
  logic [SIDE-1:0]   col_sel;
  logic [SIDE-1:0]   col_any;
  logic              blk_hit;
  logic [SPAN_W-1:0] span_log2;
  logic              q_fire;

  assign q_fire    = q_req & ~wr_en;
  assign span_log2 = SPAN_W'(SIDE_LOG2 - vbo_pkg::eff_level(int'(q_level), SIDE_LOG2));

  vbo_img_store #(.SIDE_LOG2(SIDE_LOG2)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row),
    .wr_data(wr_data), .rows(rows)
  );

  vbo_range_dec #(.SIDE_LOG2(SIDE_LOG2)) u_row_dec (
    .addr(q_row), .span_log2(span_log2), .sel(row_sel)
  );

  vbo_range_dec #(.SIDE_LOG2(SIDE_LOG2)) u_col_dec (
    .addr(q_col), .span_log2(span_log2), .sel(col_sel)
  );

  vbo_or_reduce #(.SIDE_LOG2(SIDE_LOG2)) u_reduce (
    .rows(rows), .row_sel(row_sel), .col_sel(col_sel),
    .col_any(col_any), .hit(blk_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_ack <= 1'b0;
      q_hit <= 1'b0;
    end else begin
      q_ack <= q_fire;
      q_hit <= q_fire & blk_hit;
    end
  end

  // R3
  row_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'($countones(row_sel)) == (1 << span_log2) && row_sel[q_row]);
  // R3
  col_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'($countones(col_sel)) == (1 << span_log2) && col_sel[q_col]);
  // R4
  empty_cols_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_fire && (col_any & col_sel) == '0) |=> !q_hit);
  // R7
  ack_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_fire |=> q_ack);
  // R8
  clash_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_req && wr_en) |=> !q_ack);
  // R9
  idle_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !q_ack |-> !q_hit);
endmodule

// File: tb/vbo_block_or_test.sv
`timescale 1ns/1ps
module vbo_block_or_test;
  localparam int LG = 4;
  localparam int N = 1 << LG;
  localparam int LW = $clog2(LG + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [LG-1:0] wr_row = '0;
  logic [N-1:0]  wr_data = '0;
  logic q_req = 1'b0;
  logic [LW-1:0] q_level = '0;
  logic [LG-1:0] q_row = '0;
  logic [LG-1:0] q_col = '0;
  logic q_ack, q_hit;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  vbo_block_or #(.SIDE_LOG2(LG)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row),
    .wr_data(wr_data), .q_req(q_req), .q_level(q_level),
    .q_row(q_row), .q_col(q_col), .q_ack(q_ack), .q_hit(q_hit)
  );

  // {level, row, col, expected hit}; image holds pixels (5,9) and (12,2).
  typedef struct packed {
    logic [2:0] lvl;
    logic [3:0] row;
    logic [3:0] col;
    logic       exp;
  } vec_t;
  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 4'd0,  4'd0,  1'b1},  // R5 whole image
    '{3'd1, 4'd0,  4'd0,  1'b0},  // R3 quadrants
    '{3'd1, 4'd0,  4'd8,  1'b1},
    '{3'd1, 4'd8,  4'd0,  1'b1},
    '{3'd1, 4'd8,  4'd8,  1'b0},
    '{3'd2, 4'd4,  4'd8,  1'b1},  // R4
    '{3'd2, 4'd4,  4'd12, 1'b0},
    '{3'd2, 4'd7,  4'd11, 1'b1},
    '{3'd3, 4'd12, 4'd2,  1'b1},
    '{3'd3, 4'd13, 4'd3,  1'b1},
    '{3'd3, 4'd14, 4'd2,  1'b0},
    '{3'd4, 4'd5,  4'd9,  1'b1},  // R5 single pixel
    '{3'd4, 4'd5,  4'd8,  1'b0},
    '{3'd4, 4'd12, 4'd3,  1'b0},
    '{3'd7, 4'd5,  4'd9,  1'b1},  // R6 clamp
    '{3'd5, 4'd12, 4'd2,  1'b1},
    '{3'd6, 4'd12, 4'd3,  1'b0}
  };

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic write_row(input int r, input logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_row = LG'(r); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic query(input int lvl, input int r, input int c,
                       input logic exp, input string req);
    @(negedge clk);
    q_req = 1'b1; q_level = LW'(lvl); q_row = LG'(r); q_col = LG'(c);
    @(negedge clk);
    q_req = 1'b0;
    check({req, " ack"}, q_ack, 1'b1);
    check({req, " hit"}, q_hit, exp);
    @(negedge clk);
    check("R7 ack one cycle", q_ack, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ack reset", q_ack, 1'b0);
    check("R1 hit reset", q_hit, 1'b0);
    rst_n = 1'b1;
    query(0, 0, 0, 1'b0, "R1 empty image");

    write_row(5, N'(1) << 9);
    write_row(12, N'(1) << 2);

    for (int i = 0; i < NV; i++) begin
      query(int'(VEC[i].lvl), int'(VEC[i].row), int'(VEC[i].col),
            VEC[i].exp, "R3/R4 table");
    end

    // R9: hit stays low while idle
    check("R9 idle hit", q_hit, 1'b0);

    // R2: overwrite rows and watch the whole-image answer fall
    write_row(5, '0);
    query(0, 3, 3, 1'b1, "R2 partial clear");
    write_row(12, '0);
    query(0, 3, 3, 1'b0, "R2 full clear");

    // R8: query in the same cycle as a write is rejected, write lands
    @(negedge clk);
    wr_en = 1'b1; wr_row = LG'(0); wr_data = '1;
    q_req = 1'b1; q_level = LW'(4); q_row = '0; q_col = LG'(7);
    @(negedge clk);
    wr_en = 1'b0; q_req = 1'b0;
    check("R8 no ack", q_ack, 1'b0);
    check("R9 hit while no ack", q_hit, 1'b0);
    query(4, 0, 7, 1'b1, "R8 write applied");
    query(1, 8, 8, 1'b0, "R3 other quadrant");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule